// File: doc/BRIEF.md
# Reuse Confidence Table

This block sits beside the branch predictor in the fetch unit. A queue of branch outcomes saved from a squash can offer a direction for a branch being refetched. The block decides whether that saved direction replaces the predictor's direction for the branch. It keeps one small confidence counter per table slot, and it selects the slot from the branch PC.

Queries arrive at fetch with the PC, a flag that says whether the reuse queue has an entry for this branch, that entry's direction and the predictor's direction. Two cycles later the block returns the final direction and says whether the saved result won.

Training arrives when a branch resolves. It carries the PC, the direction that had been saved for it and the direction it actually took. Training counts only when the saved entry held an executed result. A correct saved direction moves the counter up by one. A wrong one drops the counter straight to zero. The saved direction is trusted only while the counter sits at its maximum value.

Top module: `reuse_conf_table`

## Requirements
- R1: After reset every counter reads zero. `rsp_valid`, `rsp_confident`, `rsp_override` and `rsp_dir` are all 0 until a query returns.
- R2: The table has 256 slots. A PC selects the slot given by bits [9:2] of the PC. The two low alignment bits and every bit above bit 9 do not affect the choice, so PCs that differ only there share one counter.
- R3: A training with `train_executed`=1 and `train_reuse_dir`=`train_actual_dir` raises that slot's counter by one.
- R4: A counter at 31 (all ones of the 5-bit counter) stays at 31 on a further correct training. It never wraps.
- R5: A training with `train_executed`=1 and `train_reuse_dir`!=`train_actual_dir` sets that slot's counter to 0, whatever its value was.
- R6: A training with `train_executed`=0 leaves the counter unchanged.
- R7: `rsp_confident` is 1 only when the queried slot's counter equals 31.
- R8: `rsp_override` = `rsp_confident` AND the query's `query_has_reuse`. For a valid query, `rsp_dir` is `query_reuse_dir` when `rsp_override` is 1 and `query_pred_dir` otherwise. `rsp_dir`, `rsp_confident` and `rsp_override` are 0 when there is no valid query.
- R9: A query sampled at clock edge k gives its response on the outputs after edge k+1. `rsp_valid` marks the response.
- R10: A query sees every training sampled at an earlier edge, including a training sampled one edge before it. A training and a query sampled at the same edge give the query the value from before that training. Trainings to one slot on consecutive edges all accumulate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| query_valid | input | 1 | Fetch query present |
| query_pc | input | 32 | PC of the branch being fetched |
| query_has_reuse | input | 1 | Reuse queue offers a saved direction |
| query_reuse_dir | input | 1 | Saved direction (1 = taken) |
| query_pred_dir | input | 1 | Branch predictor direction |
| train_valid | input | 1 | Resolution update present |
| train_pc | input | 32 | PC of the resolving branch |
| train_executed | input | 1 | The saved entry held an executed result |
| train_reuse_dir | input | 1 | Saved direction carried with the branch |
| train_actual_dir | input | 1 | Direction the branch resolved to |
| rsp_valid | output | 1 | Response for the query from two edges earlier |
| rsp_confident | output | 1 | Slot counter is saturated |
| rsp_override | output | 1 | Saved direction replaces the predictor |
| rsp_dir | output | 1 | Final direction |

## Verification
The bench goes after the counter boundaries. The 31st correct training must flip the slot to confident. The 32nd must leave it there: a wrapping design would fall back to not confident. One wrong training must clear a saturated slot, where a decrementing design would leave it nearly full. Non-executed trainings must leave the counter untouched.

The bench also goes after ordering between back-to-back trainings to one slot and between a training and a same-cycle or next-cycle query. Missing forwarding in the read-modify-write path would lose counts. Wrong forwarding would let a query see its own cycle's training. PC aliasing across the high bits and the alignment bits is checked too, along with a full sweep of all slots after a reset that follows saturation. That sweep catches a reset that does not really clear the RAM-held counters.

// File: rtl/rct_pkg.sv
package rct_pkg;

  // Kind of change a qualified training applies to a counter.
  typedef enum logic {
    UPD_INC = 1'b0,
    UPD_CLR = 1'b1
  } upd_kind_e;

  // Query side-band carried down the response pipeline.
  typedef struct packed {
    logic vld;
    logic has;
    logic rdir;
    logic pdir;
  } qry_side_t;

endpackage

// File: rtl/rct_index.sv
module rct_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8,
  parameter int ALIGN = 2
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  logic unused_pc_bits;

  assign idx            = pc[ALIGN +: IDX_W];
  assign unused_pc_bits = ^pc;
endmodule

// File: rtl/rct_ram.sv
module rct_ram #(
  parameter int AW = 8,
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Read-before-write on a shared address; no reset on the array.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rct_vbits.sv
module rct_vbits #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set,
  input  logic [AW-1:0] sidx,
  input  logic [AW-1:0] ridx,
  output logic          rvalid
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits   <= '0;
      rvalid <= 1'b0;
    end else begin
      if (set) bits[sidx] <= 1'b1;
      rvalid <= bits[ridx];
    end
  end
endmodule

// File: rtl/rct_update.sv
module rct_update
  import rct_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  upd_kind_e        kind,
  input  logic [CNT_W-1:0] cur,
  output logic [CNT_W-1:0] nxt
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  always_comb begin
    if (kind == UPD_CLR)   nxt = '0;
    else if (cur == CMAX)  nxt = CMAX;
    else                   nxt = cur + 1'b1;
  end
endmodule

// File: rtl/reuse_conf_table.sv
module reuse_conf_table
  import rct_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8,
  parameter int ALIGN = 2,
  parameter int CNT_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            query_valid,
  input  logic [PC_W-1:0] query_pc,
  input  logic            query_has_reuse,
  input  logic            query_reuse_dir,
  input  logic            query_pred_dir,
  input  logic            train_valid,
  input  logic [PC_W-1:0] train_pc,
  input  logic            train_executed,
  input  logic            train_reuse_dir,
  input  logic            train_actual_dir,
  output logic            rsp_valid,
  output logic            rsp_confident,
  output logic            rsp_override,
  output logic            rsp_dir
);
  localparam int               NPORT = 2;   // 0: query, 1: training
  localparam logic [CNT_W-1:0] CMAX  = {CNT_W{1'b1}};

  logic [IDX_W-1:0] q_idx, t_idx;
  logic [IDX_W-1:0] rd_idx [NPORT];
  logic [CNT_W-1:0] rd_cnt [NPORT];
  logic             rd_vb  [NPORT];
  logic [CNT_W-1:0] eff    [NPORT];

  // Write port, driven by the training stage.
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [CNT_W-1:0] wr_val;

  rct_index #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_qidx (
    .pc(query_pc), .idx(q_idx)
  );
  rct_index #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_tidx (
    .pc(train_pc), .idx(t_idx)
  );

  assign rd_idx[0] = q_idx;
  assign rd_idx[1] = t_idx;

  // One replicated RAM copy per read port, all written identically.
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    rct_ram #(.AW(IDX_W), .DW(CNT_W)) u_ram (
      .clk(clk), .we(wr_en), .waddr(wr_idx), .wdata(wr_val),
      .raddr(rd_idx[p]), .rdata(rd_cnt[p])
    );
    rct_vbits #(.AW(IDX_W)) u_vb (
      .clk(clk), .rst(rst), .set(wr_en), .sidx(wr_idx),
      .ridx(rd_idx[p]), .rvalid(rd_vb[p])
    );
    assign eff[p] = rd_vb[p] ? rd_cnt[p] : '0;
  end

  // ---------------- training: stage A (capture) ----------------
  logic             ta_vld;
  upd_kind_e        ta_kind;
  logic [IDX_W-1:0] ta_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ta_vld  <= 1'b0;
      ta_kind <= UPD_INC;
      ta_idx  <= '0;
    end else begin
      ta_vld  <= train_valid & train_executed;
      ta_kind <= (train_reuse_dir == train_actual_dir) ? UPD_INC : UPD_CLR;
      ta_idx  <= t_idx;
    end
  end

  // Last write, forwarded because the RAM read missed it.
  logic             lw_vld;
  logic [IDX_W-1:0] lw_idx;
  logic [CNT_W-1:0] lw_val;
  logic [CNT_W-1:0] tb_base;

  assign tb_base = (lw_vld && lw_idx == ta_idx) ? lw_val : eff[1];

  // ---------------- training: stage B (modify, write) ----------
  rct_update #(.CNT_W(CNT_W)) u_upd (
    .kind(ta_kind), .cur(tb_base), .nxt(wr_val)
  );

  assign wr_en  = ta_vld;
  assign wr_idx = ta_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      lw_vld <= 1'b0;
      lw_idx <= '0;
      lw_val <= '0;
    end else begin
      lw_vld <= wr_en;
      lw_idx <= wr_idx;
      lw_val <= wr_val;
    end
  end

  // ---------------- query: stage 1 (read + forward capture) -----
  qry_side_t        qa;
  logic             qa_fwd;
  logic [CNT_W-1:0] qa_fval;
  logic [CNT_W-1:0] q_cnt;
  logic             q_conf;

  always_ff @(posedge clk) begin
    if (rst) begin
      qa      <= '0;
      qa_fwd  <= 1'b0;
      qa_fval <= '0;
    end else begin
      qa.vld  <= query_valid;
      qa.has  <= query_has_reuse;
      qa.rdir <= query_reuse_dir;
      qa.pdir <= query_pred_dir;
      qa_fwd  <= wr_en && (wr_idx == q_idx);
      qa_fval <= wr_val;
    end
  end

  assign q_cnt  = qa_fwd ? qa_fval : eff[0];
  assign q_conf = qa.vld && (q_cnt == CMAX);

  // ---------------- query: stage 2 (registered response) --------
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_confident <= 1'b0;
      rsp_override  <= 1'b0;
      rsp_dir       <= 1'b0;
    end else begin
      rsp_valid     <= qa.vld;
      rsp_confident <= q_conf;
      rsp_override  <= q_conf & qa.has;
      rsp_dir       <= qa.vld & ((q_conf & qa.has) ? qa.rdir : qa.pdir);
    end
  end
endmodule

// File: rtl/reuse_conf_table_chk.sv
module reuse_conf_table_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             query_valid,
  input logic             query_has_reuse,
  input logic             query_reuse_dir,
  input logic             query_pred_dir,
  input logic             train_valid,
  input logic             train_executed,
  input logic             train_reuse_dir,
  input logic             train_actual_dir,
  input logic             rsp_valid,
  input logic             rsp_confident,
  input logic             rsp_override,
  input logic             rsp_dir,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_val
);
  AST_OVR_NEEDS_CONF: assert property (@(posedge clk) disable iff (rst)
    rsp_override |-> rsp_confident); // R8
  AST_OVR_NEEDS_REUSE: assert property (@(posedge clk) disable iff (rst)
    rsp_override |-> $past(query_has_reuse, 2)); // R8
  AST_OVR_TAKES_REUSE_DIR: assert property (@(posedge clk) disable iff (rst)
    rsp_override |-> rsp_dir == $past(query_reuse_dir, 2)); // R8
  AST_PRED_DIR_KEPT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_override) |-> rsp_dir == $past(query_pred_dir, 2)); // R8
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(query_valid, 2)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !rsp_confident && !rsp_override && !rsp_dir); // R8
  AST_WRONG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($past(train_valid && train_executed && (train_reuse_dir != train_actual_dir))
     && !$past(rst)) |-> (wr_en && wr_val == '0)); // R5
  AST_UNEXECUTED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    ($past(!(train_valid && train_executed)) && !$past(rst)) |-> !wr_en); // R6
endmodule

bind reuse_conf_table reuse_conf_table_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst),
  .query_valid(query_valid), .query_has_reuse(query_has_reuse),
  .query_reuse_dir(query_reuse_dir), .query_pred_dir(query_pred_dir),
  .train_valid(train_valid), .train_executed(train_executed),
  .train_reuse_dir(train_reuse_dir), .train_actual_dir(train_actual_dir),
  .rsp_valid(rsp_valid), .rsp_confident(rsp_confident),
  .rsp_override(rsp_override), .rsp_dir(rsp_dir),
  .wr_en(wr_en), .wr_val(wr_val)
);

// File: tb/test_reuse_conf_table.sv
module test_reuse_conf_table;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32, IDX_W = 8, ALIGN = 2, CNT_W = 5;
  localparam int NSLOT = 1 << IDX_W;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic query_valid = 0, query_has_reuse = 0, query_reuse_dir = 0, query_pred_dir = 0;
  logic [PC_W-1:0] query_pc = '0, train_pc = '0;
  logic train_valid = 0, train_executed = 0, train_reuse_dir = 0, train_actual_dir = 0;
  logic rsp_valid, rsp_confident, rsp_override, rsp_dir;

  reuse_conf_table #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN), .CNT_W(CNT_W)) i_reuse_conf_table (
    .clk(clk), .rst(rst),
    .query_valid(query_valid), .query_pc(query_pc), .query_has_reuse(query_has_reuse),
    .query_reuse_dir(query_reuse_dir), .query_pred_dir(query_pred_dir),
    .train_valid(train_valid), .train_pc(train_pc), .train_executed(train_executed),
    .train_reuse_dir(train_reuse_dir), .train_actual_dir(train_actual_dir),
    .rsp_valid(rsp_valid), .rsp_confident(rsp_confident),
    .rsp_override(rsp_override), .rsp_dir(rsp_dir)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int model [NSLOT];
  // Expected-response pipeline: s1 = query of last step, s2 = two steps ago.
  bit s1_v, s1_c, s1_o, s1_d, s2_v, s2_c, s2_o, s2_d;
  string s1_t = "R1", s2_t = "R1";

  function automatic logic [PC_W-1:0] pc_of(int idx, int hi, int lo);
    return (PC_W'(hi) << (IDX_W + ALIGN)) | (PC_W'(idx) << ALIGN) | PC_W'(lo & 3);
  endfunction

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'(pc[ALIGN +: IDX_W]);
  endfunction

  task automatic check_out();
    n_chk++;
    if (rsp_valid !== s2_v || rsp_confident !== s2_c || rsp_override !== s2_o || rsp_dir !== s2_d) begin
      n_bad++;
      $display("FAIL %s: got v/c/o/d=%b%b%b%b expected %b%b%b%b at %0t", s2_t,
               rsp_valid, rsp_confident, rsp_override, rsp_dir, s2_v, s2_c, s2_o, s2_d, $time);
    end
  endtask

  task automatic clear_expect();
    foreach (model[i]) model[i] = 0;
    s1_v = 0; s1_c = 0; s1_o = 0; s1_d = 0;
    s2_v = 0; s2_c = 0; s2_o = 0; s2_d = 0;
  endtask

  // One clock cycle of stimulus; checks the response of the query two steps back.
  task automatic step(input bit tv, input logic [PC_W-1:0] tpc, input bit tx, input bit tr,
                      input bit ta, input bit qv, input logic [PC_W-1:0] qpc, input bit qh,
                      input bit qr, input bit qp, input string tag);
    bit c, o;
    @(negedge clk);
    check_out();
    train_valid = tv; train_pc = tpc; train_executed = tx;
    train_reuse_dir = tr; train_actual_dir = ta;
    query_valid = qv; query_pc = qpc; query_has_reuse = qh;
    query_reuse_dir = qr; query_pred_dir = qp;
    c = qv && (model[idx_of(qpc)] == CMAX);
    o = c && qh;
    s2_v = s1_v; s2_c = s1_c; s2_o = s1_o; s2_d = s1_d; s2_t = s1_t;
    s1_v = qv; s1_c = c; s1_o = o; s1_d = qv && (o ? qr : qp); s1_t = tag;
    if (tv && tx) begin
      if (tr == ta) model[idx_of(tpc)] = (model[idx_of(tpc)] == CMAX) ? CMAX : model[idx_of(tpc)] + 1;
      else          model[idx_of(tpc)] = 0;
    end
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, '0, 0, 0, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    train_valid = 0; query_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    clear_expect();
    s1_t = "R1"; s2_t = "R1";
    n_chk++;
    if (rsp_valid !== 0 || rsp_confident !== 0 || rsp_override !== 0 || rsp_dir !== 0) begin
      n_bad++;
      $display("FAIL R1: outputs after reset %b%b%b%b expected 0000",
               rsp_valid, rsp_confident, rsp_override, rsp_dir);
    end
  endtask

  task automatic sweep_all(string tag);
    for (int i = 0; i < NSLOT; i++) step(0, '0, 0, 0, 0, 1, pc_of(i, i, i), 1, 1, 0, tag);
    idle(2, tag);
  endtask

  task automatic saturate(int idx, string tag);
    for (int i = 0; i < CMAX; i++) step(1, pc_of(idx, 0, 0), 1, 1, 1, 0, '0, 0, 0, 0, tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    sweep_all("R1");

    // R3 R4 R7 R10: correct trainings on slot 5 with a same-cycle query each step.
    for (int i = 0; i < 40; i++)
      step(1, pc_of(5, 0, 0), 1, 1, 1, 1, pc_of(5, 0, 0), 1, 1, 0, (i < 31) ? "R3" : "R4");
    for (int i = 0; i < 3; i++) step(0, '0, 0, 0, 0, 1, pc_of(5, 0, 0), 1, 0, 1, "R7");
    // R5: a single wrong reuse clears a saturated slot.
    step(1, pc_of(5, 0, 0), 1, 1, 0, 1, pc_of(5, 0, 0), 1, 1, 0, "R5");
    step(0, '0, 0, 0, 0, 1, pc_of(5, 0, 0), 1, 1, 0, "R5");
    step(1, pc_of(5, 0, 0), 1, 0, 0, 1, pc_of(5, 0, 0), 1, 1, 0, "R5");
    idle(2, "R5");

    // R6: non-executed wrong trainings leave saturation intact.
    saturate(9, "R6");
    for (int i = 0; i < 5; i++) step(1, pc_of(9, 0, 0), 0, 1, 0, 1, pc_of(9, 0, 0), 1, 1, 0, "R6");
    idle(2, "R6");

    // R2: aliasing across high bits and alignment bits, neighbour untouched.
    for (int i = 0; i < CMAX; i++) step(1, pc_of(40, i + 3, i), 1, 0, 0, 0, '0, 0, 0, 0, "R2");
    step(0, '0, 0, 0, 0, 1, pc_of(40, 77, 3), 1, 1, 0, "R2");
    step(0, '0, 0, 0, 0, 1, pc_of(41, 0, 0), 1, 1, 0, "R2");
    step(0, '0, 0, 0, 0, 1, pc_of(39, 5, 1), 1, 1, 0, "R2");
    idle(2, "R2");

    // R8: override and direction selection combinations.
    for (int h = 0; h < 2; h++)
      for (int r = 0; r < 2; r++)
        for (int p = 0; p < 2; p++) begin
          step(0, '0, 0, 0, 0, 1, pc_of(9, 0, 0), h[0], r[0], p[0], "R8");
          step(0, '0, 0, 0, 0, 1, pc_of(5, 0, 0), h[0], r[0], p[0], "R8");
          step(0, '0, 0, 0, 0, 0, pc_of(9, 0, 0), h[0], r[0], p[0], "R8");
        end
    idle(2, "R8");

    // R9: isolated query between idle cycles.
    idle(2, "R9");
    step(0, '0, 0, 0, 0, 1, pc_of(9, 0, 0), 1, 0, 1, "R9");
    idle(3, "R9");

    // R10: back-to-back trainings, then same-cycle and next-cycle queries.
    for (int i = 0; i < CMAX - 1; i++) step(1, pc_of(20, 0, 0), 1, 0, 0, 0, '0, 0, 0, 0, "R10");
    step(1, pc_of(20, 0, 0), 1, 0, 0, 1, pc_of(20, 0, 0), 1, 1, 0, "R10");
    step(0, '0, 0, 0, 0, 1, pc_of(20, 0, 0), 1, 1, 0, "R10");
    step(1, pc_of(20, 0, 0), 1, 1, 0, 1, pc_of(20, 0, 0), 1, 1, 0, "R10");
    step(0, '0, 0, 0, 0, 1, pc_of(20, 0, 0), 1, 1, 0, "R10");
    idle(2, "R10");

    // Mixed random traffic over a few slots, mostly correct reuse.
    for (int i = 0; i < 4000; i++) begin
      int ts = 100 + int'($urandom_range(0, 5));
      int qs = 100 + int'($urandom_range(0, 5));
      bit tr = 1'($urandom);
      bit ta = ($urandom_range(0, 63) == 0) ? !tr : tr;
      step(1'($urandom), pc_of(ts, int'($urandom_range(0, 15)), int'($urandom_range(0, 3))),
           ($urandom_range(0, 7) != 0), tr, ta,
           1'($urandom), pc_of(qs, int'($urandom_range(0, 15)), 0),
           1'($urandom), 1'($urandom), 1'($urandom), "R3");
    end
    idle(2, "R3");

    // R1: reset after saturation clears every slot.
    saturate(200, "R1");
    idle(2, "R1");
    do_reset();
    sweep_all("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule